// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is the command state machine inside a model of a 128K x 16 NOR flash. It takes bus write cycles and bus read requests that are already qualified. It recognises multi-cycle unlock sequences. These start embedded word programs, chip and sector erases, a sticky boot-region write lock, and entry to and exit from an identification mode. Each embedded operation runs for a number of clock cycles set by a parameter. At the end of that count, the block issues a single request to an external array port. During the operation, reads return polling status in place of array contents.

The array itself sits outside the block. The block reads the old word through the same address port, so a program can only clear bits. An erase request carries a four-bit region select: boot, parameter block 1, parameter block 2 and main array. A halt input aborts any operation and floats the read bus. A high-voltage override input lifts the boot lock while it is held high.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After power-on reset, busy is low, no array request is issued, and a read of any address returns the array word on rd_data with rd_oe high only while rd_en is high.
- R2: A word program is four writes: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then the target address and data. The stored word becomes old AND new. Only data bits 7:0 of the command writes are compared.
- R3: busy rises on the clock edge that accepts the final command write and stays high for exactly PROG_CYC cycles (program) or ERASE_CYC cycles (erase). Every write accepted while busy is ignored.
- R4: While busy, a read returns the complement of the programmed data bit 7 on bit 7 during a program, or 0 on bit 7 during an erase. Bit 6 inverts on each successive read.
- R5: Writing AA/55/80/AA/55 and then 0x10 to 0x5555 erases every region to 0xFFFF.
- R6: The same prefix followed by 0x30 selects a sector by address bits 16:12. Code 0x03 erases 0x02000–0x03FFF. Code 0x05 erases 0x04000–0x05FFF. Code 0x1F erases 0x06000–0x1FFFF, and also 0x00000–0x01FFF while the lock is clear. Any other code starts nothing.
- R7: The prefix followed by 0x40 to 0x5555 sets the boot lock. While the lock is set and hv_override is low, the following start nothing and leave the array unchanged: chip erase, and any program to 0x00000–0x01FFF. A main-array sector erase then leaves the boot range untouched.
- R8: With hv_override high, programs, chip erase and main sector erase act on the boot range even when locked.
- R9: AA/55/0x90 enters identification mode. In this mode, reads of address 0, 1 and 2 return 0x001F, 0x0082 and the lock flag on bit 0. The mode is left by AA/55/0xF0 or by a single 0xF0 to any address.
- R10: A write that breaks an expected sequence discards it and starts nothing. An 0xAA to 0x5555 instead restarts the prefix.
- R11: While halt_n is low, rd_oe stays low, and busy is low from the next edge on. The aborted operation never reaches the array. The lock flag survives a halt and is cleared only by por_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; also clears the lock |
| halt_n | input | 1 | Operation abort and output float, active low |
| hv_override | input | 1 | Boot lock override while high |
| wr_en | input | 1 | Qualified write cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data (0 when not driven) |
| rd_oe | output | 1 | Read bus drive enable |
| busy | output | 1 | Embedded operation in progress |
| arr_addr | output | AW | Array address (target while busy, else rd_addr) |
| arr_rdata | input | DW | Array word at arr_addr |
| arr_prog | output | 1 | One-cycle program request |
| arr_wdata | output | DW | Word to store on arr_prog |
| arr_erase | output | 1 | One-cycle erase request |
| arr_erase_sel | output | 4 | Erase regions: bit0 boot, bit1 param 1, bit2 param 2, bit3 main |

## Verification
Two events can land in the same cycle. The first is the last counted cycle of an operation, where the array commit fires. The second is either a new command write or a halt. Both are provoked on purpose. A complete program sequence is written while a previous program is still running. The bench then confirms by reading back that the later target was never touched. A halt is dropped partway through a program, and the read-back shows the old word intact and busy falling on the next edge. Busy length is measured by counting edges from the accepting write.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int AW        = 17,
  parameter int DW        = 16,
  parameter int PROG_CYC  = 24,
  parameter int ERASE_CYC = 64
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          halt_n,
  input  logic          hv_override,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe,
  output logic          busy,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_rdata,
  output logic          arr_prog,
  output logic [DW-1:0] arr_wdata,
  output logic          arr_erase,
  output logic [3:0]    arr_erase_sel
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PCNT = CW'(PROG_CYC);
  localparam logic [CW-1:0] ECNT = CW'(ERASE_CYC);

  typedef enum logic [2:0] {ST_IDLE, ST_U1, ST_U2, ST_PDAT, ST_E1, ST_E2, ST_E3} st_t;

  st_t           st;
  logic          id_mode, lock_q, op_erase, tog;
  logic [CW-1:0] cnt;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data;
  logic [3:0]    esel;
  logic [DW-1:0] rval;

  wire [7:0] lo       = wr_data[7:0];
  wire       at_5555  = wr_addr == AW'(17'h05555);
  wire       at_2aaa  = wr_addr == AW'(17'h02AAA);
  wire       restart  = at_5555 && lo == 8'hAA;
  wire       protect  = lock_q && !hv_override;
  wire       wr_boot  = wr_addr < AW'(17'h02000);
  wire [4:0] sec_code = wr_addr[AW-1:AW-5];
  wire       wr_ok    = wr_en && halt_n && !busy;
  wire       commit   = halt_n && cnt == CW'(1);

  assign busy          = cnt != '0;
  assign arr_prog      = commit && !op_erase;
  assign arr_erase     = commit && op_erase;
  assign arr_erase_sel = esel;
  assign arr_addr      = busy ? tgt_addr : rd_addr;
  assign arr_wdata     = arr_rdata & tgt_data;
  assign rd_oe         = rd_en && halt_n;
  assign rd_data       = rd_oe ? rval : '0;

  always_comb begin
    rval = '0;
    if (busy) begin
      rval[7] = op_erase ? 1'b0 : ~tgt_data[7];
      rval[6] = tog;
    end else if (id_mode) begin
      if (rd_addr == '0)            rval = DW'(16'h001F);
      else if (rd_addr == AW'(1))   rval = DW'(16'h0082);
      else if (rd_addr == AW'(2))   rval[0] = lock_q;
    end else begin
      rval = arr_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      st <= ST_IDLE; id_mode <= 1'b0; lock_q <= 1'b0; op_erase <= 1'b0;
      tog <= 1'b0; cnt <= '0; tgt_addr <= '0; tgt_data <= '0; esel <= '0;
    end else if (!halt_n) begin
      st <= ST_IDLE; id_mode <= 1'b0; tog <= 1'b0; cnt <= '0;
    end else begin
      if (busy) cnt <= cnt - CW'(1);
      if (busy && rd_en) tog <= ~tog;
      if (wr_ok) begin
        st <= restart ? ST_U1 : ST_IDLE;
        case (st)
          ST_IDLE: if (!restart && lo == 8'hF0) id_mode <= 1'b0;
          ST_U1: begin
            if (at_2aaa && lo == 8'h55) st <= ST_U2;
            else if (lo == 8'hF0) id_mode <= 1'b0;
          end
          ST_U2: begin
            if (at_5555 && lo == 8'hA0)      st <= ST_PDAT;
            else if (at_5555 && lo == 8'h80) st <= ST_E1;
            else if (at_5555 && lo == 8'h90) id_mode <= 1'b1;
            else if (lo == 8'hF0)            id_mode <= 1'b0;
          end
          ST_PDAT: begin
            st <= ST_IDLE;
            if (!(wr_boot && protect)) begin
              cnt <= PCNT; op_erase <= 1'b0; tgt_addr <= wr_addr; tgt_data <= wr_data;
            end
          end
          ST_E1: begin
            if (restart) st <= ST_E2;
            else if (lo == 8'hF0) id_mode <= 1'b0;
          end
          ST_E2: begin
            if (at_2aaa && lo == 8'h55) st <= ST_E3;
            else if (lo == 8'hF0) id_mode <= 1'b0;
          end
          ST_E3: begin
            if (at_5555 && lo == 8'h10) begin
              if (!protect) begin
                cnt <= ECNT; op_erase <= 1'b1; esel <= 4'b1111; tgt_data <= '0;
              end
            end else if (at_5555 && lo == 8'h40) begin
              lock_q <= 1'b1;
            end else if (lo == 8'h30) begin
              tgt_data <= '0;
              tgt_addr <= wr_addr;
              case (sec_code)
                5'h03: begin cnt <= ECNT; op_erase <= 1'b1; esel <= 4'b0010; end
                5'h05: begin cnt <= ECNT; op_erase <= 1'b1; esel <= 4'b0100; end
                5'h1F: begin
                  cnt <= ECNT; op_erase <= 1'b1;
                  esel <= protect ? 4'b1000 : 4'b1001;
                end
                default: ;
              endcase
            end else if (lo == 8'hF0) id_mode <= 1'b0;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R3
  commit_in_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
    (arr_prog || arr_erase) |-> busy);
  // R3
  commit_ends_op_chk: assert property (@(posedge clk) disable iff (!por_n)
    (arr_prog || arr_erase) |=> !busy);
  // R11
  halt_abort_chk: assert property (@(posedge clk) disable iff (!por_n)
    !halt_n |=> !busy);
  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q);
  // R11
  halt_float_chk: assert property (@(posedge clk) disable iff (!por_n)
    !halt_n |-> !rd_oe);
endmodule

// File: tb/flash_cmd_fsm_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_fsm_tb_top;
  localparam int PC = 24;
  localparam int EC = 64;

  logic clk = 0, por_n = 0, halt_n = 1, hv = 0;
  logic wr_en = 0, rd_en = 0;
  logic [16:0] wr_addr = '0, rd_addr = '0, arr_addr;
  logic [15:0] wr_data = '0, rd_data, arr_rdata, arr_wdata;
  logic rd_oe, busy, arr_prog, arr_erase;
  logic [3:0] arr_erase_sel;
  logic [15:0] mem [8];
  logic [15:0] expv [8];
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  flash_cmd_fsm #(.AW(17), .DW(16), .PROG_CYC(PC), .ERASE_CYC(EC)) dut_i (
    .clk(clk), .por_n(por_n), .halt_n(halt_n), .hv_override(hv),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_oe(rd_oe), .busy(busy),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .arr_prog(arr_prog),
    .arr_wdata(arr_wdata), .arr_erase(arr_erase), .arr_erase_sel(arr_erase_sel));

  function automatic logic [16:0] saddr(input int i);
    case (i)
      0: return 17'h00010; 1: return 17'h01FFF; 2: return 17'h02010; 3: return 17'h03FFF;
      4: return 17'h04010; 5: return 17'h05FFF; 6: return 17'h06000; default: return 17'h1FFFF;
    endcase
  endfunction

  always_comb begin
    arr_rdata = 16'hFFFF;
    for (int i = 0; i < 8; i++) if (arr_addr == saddr(i)) arr_rdata = mem[i];
  end

  always @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (!por_n) mem[i] <= 16'hFFFF;
      else if (arr_prog && arr_addr == saddr(i)) mem[i] <= arr_wdata;
      else if (arr_erase && arr_erase_sel[i/2]) mem[i] <= 16'hFFFF;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic wr(input logic [16:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic rd(input logic [16:0] a, output logic [15:0] v);
    @(negedge clk); rd_en = 1; rd_addr = a; #1; v = rd_data;
    @(posedge clk); #1; rd_en = 0;
  endtask

  task automatic ul(); wr(17'h05555, 16'h3CAA); wr(17'h02AAA, 16'hC355); endtask
  task automatic prog(input logic [16:0] a, input logic [15:0] d);
    ul(); wr(17'h05555, 16'h77A0); wr(a, d);
  endtask
  task automatic ers(input logic [16:0] a, input logic [7:0] code);
    ul(); wr(17'h05555, 16'h0080); ul(); wr(a, {8'h5A, code});
  endtask
  task automatic wait_idle(); while (busy) begin @(posedge clk); #1; end endtask
  task automatic check_all(input string req);
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin rd(saddr(i), v); chk(v == expv[i], req, v, expv[i]); end
  endtask
  task automatic erase_regions(input logic [3:0] sel);
    for (int i = 0; i < 8; i++) if (sel[i/2]) expv[i] = 16'hFFFF;
  endtask

  initial begin
    #(8 * 150000);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    int n;
    for (int i = 0; i < 8; i++) expv[i] = 16'hFFFF;
    repeat (3) @(posedge clk); #1; por_n = 1;
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(rd_oe == 0, "R1 rd_oe idle", rd_oe, 0);
    check_all("R1 erased read");

    // R2 R3 program sweep, two passes for AND behaviour
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 8; i++) begin
        logic [15:0] d = (p == 0) ? (16'hF0F0 ^ 16'(i * 16'h1357)) : (16'h3CFF ^ 16'(i * 16'h0421));
        prog(saddr(i), d);
        n = 0;
        while (busy) begin n++; @(posedge clk); #1; end
        chk(n == PC, "R3 program length", n, PC);
        expv[i] = expv[i] & d;
      end
      check_all("R2 program AND");
    end

    // R4 polling on program, R3 writes ignored while busy
    ers(17'h1F000, 8'h30); wait_idle(); erase_regions(4'b1001);
    prog(saddr(6), 16'h1280);
    rd(saddr(6), v); chk(v[7] == 1'b0, "R4 program bit7", v, 0);
    rd(saddr(6), v2); chk(v2[6] != v[6], "R4 toggle", v2, ~v);
    prog(saddr(7), 16'h0000);
    wait_idle(); expv[6] = 16'h1280;
    chk(!busy, "R3 ignored write no busy", busy, 0);
    check_all("R3 ignored during busy");

    // R6 sector erases
    ers(17'h03123, 8'h30);
    rd(17'h00000, v); chk(v[7] == 1'b0, "R4 erase bit7", v, 0);
    rd(17'h00000, v2); chk(v2[6] != v[6], "R4 erase toggle", v2, ~v);
    wait_idle(); erase_regions(4'b0010); check_all("R6 param1");
    ers(17'h05ABC, 8'h30); n = 0;
    while (busy) begin n++; @(posedge clk); #1; end
    chk(n == EC, "R3 erase length", n, EC);
    erase_regions(4'b0100); check_all("R6 param2");
    ers(17'h08000, 8'h30); chk(!busy, "R6 bad sector", busy, 0); check_all("R6 bad sector");

    // R5 chip erase
    for (int i = 0; i < 8; i++) begin prog(saddr(i), 16'h0F0F); wait_idle(); expv[i] = expv[i] & 16'h0F0F; end
    ers(17'h05555, 8'h10); wait_idle(); erase_regions(4'b1111); check_all("R5 chip erase");

    // R9 identification mode
    ul(); wr(17'h05555, 16'h0090);
    rd(17'h0, v); chk(v == 16'h001F, "R9 id0", v, 16'h001F);
    rd(17'h1, v); chk(v == 16'h0082, "R9 id1", v, 16'h0082);
    rd(17'h2, v); chk(v == 16'h0000, "R9 id2 unlocked", v, 0);
    wr(17'h12345, 16'h00F0); check_all("R9 exit single");
    ul(); wr(17'h05555, 16'h0090); ul(); wr(17'h05555, 16'h00F0);
    check_all("R9 exit sequence");

    // R10 broken and restarted sequences
    ul(); wr(17'h05555, 16'h0012); wr(saddr(2), 16'h0000);
    chk(!busy, "R10 broken no busy", busy, 0);
    wr(17'h05555, 16'h00AA); wr(17'h01234, 16'h0055); wr(17'h05555, 16'h00A0); wr(saddr(3), 16'h0000);
    chk(!busy, "R10 bad addr no busy", busy, 0);
    check_all("R10 discarded");
    wr(17'h05555, 16'h00AA); ul(); wr(17'h05555, 16'h00A0); wr(saddr(4), 16'h00FF);
    wait_idle(); expv[4] = 16'h00FF; check_all("R10 restart");

    // R7 lock
    prog(saddr(0), 16'hAAAA); wait_idle(); expv[0] = 16'hAAAA;
    ers(17'h05555, 8'h40);
    ul(); wr(17'h05555, 16'h0090); rd(17'h2, v); chk(v == 16'h0001, "R7 lock flag", v, 1);
    wr(17'h00000, 16'h00F0);
    prog(saddr(1), 16'h0000); chk(!busy, "R7 boot program blocked", busy, 0);
    ers(17'h05555, 8'h10); chk(!busy, "R7 chip erase blocked", busy, 0);
    prog(saddr(7), 16'h1111); wait_idle(); expv[7] = 16'h1111;
    ers(17'h1F000, 8'h30); wait_idle(); erase_regions(4'b1000);
    check_all("R7 locked");

    // R8 override
    hv = 1;
    prog(saddr(1), 16'h5555); wait_idle(); expv[1] = 16'h5555;
    check_all("R8 override program");
    ers(17'h1F000, 8'h30); wait_idle(); erase_regions(4'b1001);
    check_all("R8 override sector");
    hv = 0;

    // R11 halt aborts; lock survives
    prog(saddr(5), 16'h0000);
    repeat (3) @(posedge clk);
    @(negedge clk); halt_n = 0; rd_en = 1; rd_addr = saddr(5); #1;
    chk(rd_oe == 0, "R11 float", rd_oe, 0);
    chk(rd_data == 16'h0, "R11 data idle", rd_data, 0);
    @(posedge clk); #1; chk(!busy, "R11 busy cleared", busy, 0);
    halt_n = 1; rd_en = 0;
    repeat (PC + 2) @(posedge clk); #1;
    check_all("R11 aborted program");
    ul(); wr(17'h05555, 16'h0090); rd(17'h2, v); chk(v == 16'h0001, "R11 lock kept", v, 1);
    @(negedge clk); por_n = 0; @(posedge clk); #1; por_n = 1;
    ul(); wr(17'h05555, 16'h0090); rd(17'h2, v); chk(v == 16'h0000, "R11 lock cleared by por", v, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule